// File: doc/BRIEF.md
# Mixed-Width Dual-Port Block Memory

This block is a synchronous memory with two independent ports, A and B, over one shared storage array. Each port has its own clock enable, address, write data, write enable, read enable and registered read data. The two ports may be given different data widths, so a word written through the narrow port appears as a slice of a wider word on the other port, and the reverse. A family parameter picks between a small array of 8192 bits and a large array of 131072 bits. Parity-style widths, which are multiples of nine, enlarge the array by one ninth: 9216 or 147456 bits.

Widths fall into two groups. The first group holds the power-of-two widths: 1, 2, 4, 8 and 16 in the small family, and 8, 16 and 32 in the large family. The second group holds the multiple-of-nine widths: 9 and 18 in the small family, and 9, 18 and 36 in the large family. Both ports must take their widths from the same group. Any other pairing stops elaboration with a fatal error.

A parameter sets what a read returns when the location it reads is being written in the same cycle: the freshly written value, or the previous contents. The block does not arbitrate two writes to the same location. It raises a flag for such a cycle and, when its simulation option is set, stores unknown values there.

Top module: `mwtdp_ram`

## Requirements
- R1: While reset is asserted, `a_rdata`, `b_rdata` and `conflict` are all zero. Reset does not clear the storage.
- R2: Storage is organised in words of the narrower port width. A wide word at address n covers narrow words n*R through n*R+R-1, where R is the width ratio, and the lowest narrow word sits in the least significant bits. Data written on one port is therefore readable, correctly sliced, on the other port.
- R3: A read is accepted on a rising edge where the port's `ce` and `re` inputs are both high. Its data appears on that port's `rdata` right after that edge.
- R4: When `ce` or `re` is low at an edge, that port's `rdata` keeps its previous value, even if its address changes.
- R5: A write takes place only when both `ce` and `we` are high. With `ce` low, `we` and the write data have no effect on the storage.
- R6: With `RDW_NEW`=1, a read of a narrow word that either port writes in the same cycle returns the new value, and the reading port's own write takes priority. With `RDW_NEW`=0, such a read returns the contents held before that edge.
- R7: `conflict` is high for exactly the one cycle after an edge at which both ports write and their narrow-word ranges overlap. It is low after every other edge.
- R8: Every location, including address 0 and the highest address, can be reached from either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| a_ce | input | 1 | Port A clock enable |
| a_we | input | 1 | Port A write enable |
| a_re | input | 1 | Port A read enable |
| a_addr | input | A_AW | Port A word address |
| a_wdata | input | A_WIDTH | Port A write data |
| a_rdata | output | A_WIDTH | Port A registered read data |
| b_ce | input | 1 | Port B clock enable |
| b_we | input | 1 | Port B write enable |
| b_re | input | 1 | Port B read enable |
| b_addr | input | B_AW | Port B word address |
| b_wdata | input | B_WIDTH | Port B write data |
| b_rdata | output | B_WIDTH | Port B registered read data |
| conflict | output | 1 | Overlapping dual write occurred on the previous edge |

## Verification
The assertions check same-port read-after-write only in cycles where port B is not writing, because a simultaneous write from the other port could change the stored value. They check the new-data read-during-write case only in the same way. The assertions also rely on a legal width pair fixed at elaboration. The stimulus never reads a narrow word whose contents were left undefined by an overlapping dual write. Every word it reads has first been written through one of the ports, so the bench's byte-array model always holds a defined expected value.

// File: rtl/mwtdp_ram.sv
module mwtdp_ram #(
  parameter int FAMILY  = 0,
  parameter int A_WIDTH = 8,
  parameter int B_WIDTH = 16,
  parameter bit RDW_NEW = 1'b1,
  parameter bit SIM_X   = 1'b1,
  localparam bit PAR    = (A_WIDTH % 9 == 0),
  localparam int TOTAL  = ((FAMILY == 0) ? 8192 : 131072) / 8 * (PAR ? 9 : 8),
  localparam int A_AW   = $clog2(TOTAL / A_WIDTH),
  localparam int B_AW   = $clog2(TOTAL / B_WIDTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               a_ce,
  input  logic               a_we,
  input  logic               a_re,
  input  logic [A_AW-1:0]    a_addr,
  input  logic [A_WIDTH-1:0] a_wdata,
  output logic [A_WIDTH-1:0] a_rdata,
  input  logic               b_ce,
  input  logic               b_we,
  input  logic               b_re,
  input  logic [B_AW-1:0]    b_addr,
  input  logic [B_WIDTH-1:0] b_wdata,
  output logic [B_WIDTH-1:0] b_rdata,
  output logic               conflict
);

  function automatic bit pow2_ok(int w);
    if (FAMILY == 0) return (w == 1 || w == 2 || w == 4 || w == 8 || w == 16);
    return (w == 8 || w == 16 || w == 32);
  endfunction

  function automatic bit nine_ok(int w);
    if (FAMILY == 0) return (w == 9 || w == 18);
    return (w == 9 || w == 18 || w == 36);
  endfunction

  localparam bit LEGAL = (pow2_ok(A_WIDTH) && pow2_ok(B_WIDTH)) ||
                         (nine_ok(A_WIDTH) && nine_ok(B_WIDTH));
  localparam int NW    = (A_WIDTH < B_WIDTH) ? A_WIDTH : B_WIDTH;
  localparam int RA    = A_WIDTH / NW;
  localparam int RB    = B_WIDTH / NW;
  localparam int DEPTH = TOTAL / NW;

  generate
    if (!LEGAL) begin : g_bad_pair
      $fatal(1, "mwtdp_ram: width pair %0d/%0d not allowed", A_WIDTH, B_WIDTH);
    end
  endgenerate

  logic [NW-1:0] mem [DEPTH];

  wire a_wr = a_ce && a_we;
  wire b_wr = b_ce && b_we;
  wire a_rd = a_ce && a_re;
  wire b_rd = b_ce && b_re;

  int a_base, b_base;
  assign a_base = int'(a_addr) * RA;
  assign b_base = int'(b_addr) * RB;

  wire overlap = (a_base < b_base + RB) && (b_base < a_base + RA);

  logic [A_WIDTH-1:0] a_nx;
  logic [B_WIDTH-1:0] b_nx;

  always_comb begin
    a_nx = '0;
    for (int i = 0; i < RA; i++) begin
      int idx;
      logic [NW-1:0] w;
      idx = a_base + i;
      w = mem[idx];
      if (RDW_NEW) begin
        if (b_wr && idx >= b_base && idx < b_base + RB) w = b_wdata[(idx-b_base)*NW +: NW];
        if (a_wr) w = a_wdata[i*NW +: NW];
      end
      a_nx[i*NW +: NW] = w;
    end
  end

  always_comb begin
    b_nx = '0;
    for (int j = 0; j < RB; j++) begin
      int idx;
      logic [NW-1:0] w;
      idx = b_base + j;
      w = mem[idx];
      if (RDW_NEW) begin
        if (a_wr && idx >= a_base && idx < a_base + RA) w = a_wdata[(idx-a_base)*NW +: NW];
        if (b_wr) w = b_wdata[j*NW +: NW];
      end
      b_nx[j*NW +: NW] = w;
    end
  end

  always_ff @(posedge clk) begin
    if (a_wr)
      for (int i = 0; i < RA; i++) mem[a_base+i] <= a_wdata[i*NW +: NW];
    if (b_wr)
      for (int j = 0; j < RB; j++) mem[b_base+j] <= b_wdata[j*NW +: NW];
    if (SIM_X && a_wr && b_wr && overlap)
      for (int i = 0; i < RA; i++)
        if (a_base + i >= b_base && a_base + i < b_base + RB) mem[a_base+i] <= 'x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata  <= '0;
      b_rdata  <= '0;
      conflict <= 1'b0;
    end else begin
      if (a_rd) a_rdata <= a_nx;
      if (b_rd) b_rdata <= b_nx;
      conflict <= a_wr && b_wr && overlap;
    end
  end

endmodule

// File: rtl/mwtdp_ram_chk.sv
module mwtdp_ram_chk #(
  parameter int A_WIDTH = 8,
  parameter int B_WIDTH = 16,
  parameter int A_AW    = 10,
  parameter int B_AW    = 9,
  parameter bit RDW_NEW = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               a_ce,
  input logic               a_we,
  input logic               a_re,
  input logic [A_AW-1:0]    a_addr,
  input logic [A_WIDTH-1:0] a_wdata,
  input logic [A_WIDTH-1:0] a_rdata,
  input logic               b_ce,
  input logic               b_we,
  input logic               b_re,
  input logic [B_WIDTH-1:0] b_rdata,
  input logic               conflict
);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (a_rdata == '0 && b_rdata == '0 && !conflict));

  a_r4_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_ce && a_re) |=> $stable(a_rdata));

  a_r4_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_ce && b_re) |=> $stable(b_rdata));

  a_r7_flag_needs_dual_write: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> $past(a_ce && a_we && b_ce && b_we));

  a_r7_flag_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_ce && a_we && b_ce && b_we) |=> !conflict);

  a_r3_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(a_ce && a_we && !(b_ce && b_we)) && a_ce && a_re && !a_we &&
     !(b_ce && b_we) && a_addr == $past(a_addr))
    |=> a_rdata == $past(a_wdata, 2));

  generate
    if (RDW_NEW) begin : g_new
      a_r6_new_data_own: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ce && a_we && a_re && !(b_ce && b_we)) |=> a_rdata == $past(a_wdata));
    end
  endgenerate

endmodule

bind mwtdp_ram mwtdp_ram_chk #(
  .A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH), .A_AW(A_AW), .B_AW(B_AW), .RDW_NEW(RDW_NEW)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_ce(a_ce), .a_we(a_we), .a_re(a_re), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
  .b_ce(b_ce), .b_we(b_we), .b_re(b_re), .b_rdata(b_rdata), .conflict(conflict)
);

// File: tb/test_mwtdp_ram.sv
module test_mwtdp_ram;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic a_ce = 0, a_we = 0, a_re = 0;
  logic [9:0] a_addr = '0;
  logic [7:0] a_wdata = '0;
  logic b_ce = 0, b_we = 0, b_re = 0;
  logic [8:0] b_addr = '0;
  logic [15:0] b_wdata = '0;
  logic [7:0] a_rd_n, a_rd_o;
  logic [15:0] b_rd_n, b_rd_o;
  logic cf_n, cf_o;

  mwtdp_ram #(.FAMILY(0), .A_WIDTH(8), .B_WIDTH(16), .RDW_NEW(1'b1), .SIM_X(1'b1)) i_mwtdp_ram (
    .clk(clk), .rst_n(rst_n),
    .a_ce(a_ce), .a_we(a_we), .a_re(a_re), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rd_n),
    .b_ce(b_ce), .b_we(b_we), .b_re(b_re), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rd_n),
    .conflict(cf_n));

  mwtdp_ram #(.FAMILY(0), .A_WIDTH(8), .B_WIDTH(16), .RDW_NEW(1'b0), .SIM_X(1'b1)) i_mwtdp_ram_old (
    .clk(clk), .rst_n(rst_n),
    .a_ce(a_ce), .a_we(a_we), .a_re(a_re), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rd_o),
    .b_ce(b_ce), .b_we(b_we), .b_re(b_re), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rd_o),
    .conflict(cf_o));

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] shadow [1024];

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    a_ce = 0; a_we = 0; a_re = 0; b_ce = 0; b_we = 0; b_re = 0;
  endtask

  task automatic a_write(int ad, logic [7:0] d);
    idle(); a_ce = 1; a_we = 1; a_addr = 10'(ad); a_wdata = d;
    tick(); shadow[ad] = d; idle();
  endtask

  task automatic b_write(int ad, logic [15:0] d);
    idle(); b_ce = 1; b_we = 1; b_addr = 9'(ad); b_wdata = d;
    tick(); shadow[2*ad] = d[7:0]; shadow[2*ad+1] = d[15:8]; idle();
  endtask

  task automatic a_read(string req, int ad);
    idle(); a_ce = 1; a_re = 1; a_addr = 10'(ad);
    tick();
    chk(req, 16'(a_rd_n), 16'(shadow[ad]));
    chk(req, 16'(a_rd_o), 16'(shadow[ad]));
    idle();
  endtask

  task automatic b_read(string req, int ad);
    idle(); b_ce = 1; b_re = 1; b_addr = 9'(ad);
    tick();
    chk(req, b_rd_n, {shadow[2*ad+1], shadow[2*ad]});
    chk(req, b_rd_o, {shadow[2*ad+1], shadow[2*ad]});
    idle();
  endtask

  task automatic t_reset();
    chk("R1", 16'(a_rd_n), 16'h0);
    chk("R1", b_rd_n, 16'h0);
    chk("R1", {15'h0, cf_n}, 16'h0);
  endtask

  task automatic t_cross_width();
    a_write(10, 8'h3C);
    a_write(11, 8'hA5);
    b_read("R2", 5);
    b_write(20, 16'hBEEF);
    a_read("R2", 40);
    a_read("R3", 41);
  endtask

  task automatic t_hold();
    a_read("R3", 40);
    a_ce = 1; a_re = 0; a_addr = 10'd41;
    tick();
    chk("R4", 16'(a_rd_n), 16'h00EF);
    a_ce = 0; a_re = 1;
    tick();
    chk("R4", 16'(a_rd_o), 16'h00EF);
    idle();
    b_read("R2", 20);
    b_ce = 1; b_re = 0; b_addr = 9'd5;
    tick();
    chk("R4", b_rd_n, 16'hBEEF);
    idle();
  endtask

  task automatic t_ce_write();
    a_ce = 0; a_we = 1; a_addr = 10'd40; a_wdata = 8'h55;
    tick();
    idle();
    a_read("R5", 40);
  endtask

  task automatic t_rdw();
    a_write(100, 8'h34);
    a_ce = 1; a_we = 1; a_re = 1; a_addr = 10'd100; a_wdata = 8'h12;
    tick();
    chk("R6 new own", 16'(a_rd_n), 16'h0012);
    chk("R6 old own", 16'(a_rd_o), 16'h0034);
    shadow[100] = 8'h12;
    idle();
    b_write(50, 16'h9988);
    b_ce = 1; b_we = 1; b_addr = 9'd50; b_wdata = 16'hABCD;
    a_ce = 1; a_re = 1; a_addr = 10'd100;
    tick();
    chk("R6 new cross", 16'(a_rd_n), 16'h00CD);
    chk("R6 old cross", 16'(a_rd_o), 16'h0088);
    shadow[100] = 8'hCD; shadow[101] = 8'hAB;
    idle();
    a_ce = 1; a_we = 1; a_addr = 10'd101; a_wdata = 8'h77;
    b_ce = 1; b_re = 1; b_addr = 9'd50;
    tick();
    chk("R6 new cross wide", b_rd_n, 16'h77CD);
    chk("R6 old cross wide", b_rd_o, 16'hABCD);
    shadow[101] = 8'h77;
    idle();
    b_read("R6", 50);
  endtask

  task automatic t_conflict();
    a_ce = 1; a_we = 1; a_addr = 10'd200; a_wdata = 8'h11;
    b_ce = 1; b_we = 1; b_addr = 9'd100; b_wdata = 16'h2233;
    tick();
    chk("R7 raised", {15'h0, cf_n}, 16'h1);
    chk("R7 raised", {15'h0, cf_o}, 16'h1);
    shadow[201] = 8'h22;
    idle();
    tick();
    chk("R7 one cycle", {15'h0, cf_n}, 16'h0);
    a_ce = 1; a_we = 1; a_addr = 10'd300; a_wdata = 8'h44;
    b_ce = 1; b_we = 1; b_addr = 9'd101; b_wdata = 16'h5566;
    tick();
    chk("R7 disjoint", {15'h0, cf_n}, 16'h0);
    shadow[300] = 8'h44; shadow[202] = 8'h66; shadow[203] = 8'h55;
    idle();
    a_read("R7", 201);
    a_read("R7", 300);
    b_read("R7", 101);
  endtask

  task automatic t_corners();
    a_write(1022, 8'h21);
    a_write(1023, 8'h9A);
    b_read("R8", 511);
    b_write(0, 16'h0F1E);
    a_read("R8", 0);
    a_read("R8", 1);
  endtask

  bit done = 0;

  initial begin
    idle();
    tick(); tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_cross_width();
    t_hold();
    t_ce_write();
    t_rdw();
    t_conflict();
    t_corners();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule